// File: doc/BRIEF.md
# Physical Memory Protection Access Checker

This block decides whether one memory access may proceed under RISC-V Physical Memory Protection. A request carries the byte start address, the access length in bytes, the access kind (read, write or execute) and the privilege mode of the hart. The protection entries arrive as two flat vectors from the configuration register bank: one configuration byte per entry and one address register per entry. One cycle after a request the block returns a permit or deny flag, which the memory path turns into an access fault.

The access is cut into the aligned 4-byte words it touches, and every word is matched against every entry. Entries are searched from index 0 upward. The first entry that touches any word of the access decides the result, and it must cover every word; an access that straddles an entry's edge is refused. Each entry can use one of three region forms: a top-of-range window bounded by the previous entry's address, a single naturally aligned word, or a naturally aligned power-of-two block.

Top module: `pmp_access_checker`

## Requirements
- R1: The result is registered. `rsp_valid` is high in exactly the cycle after a cycle with `req_valid` high. `rsp_allow` is low whenever `rsp_valid` is low.
- R2: When every entry's mode field is 0 (OFF), every access is permitted, whatever its kind or privilege.
- R3: Entry i's configuration byte is `cfg_bytes[8*i+7:8*i]`. In that byte, bit 0 grants read, bit 1 grants write, bit 2 grants execute, bits 4:3 select the mode (0 OFF, 1 top-of-range, 2 single word, 3 power-of-two block) and bit 7 is the lock. Entry i's address register is `cfg_addr[30*i+29:30*i]` and holds byte address bits 31:2.
- R4: A single-word entry matches exactly the word whose address bits 31:2 equal its address register. A locked single-word entry without read permission denies a machine-mode load to that word.
- R5: A top-of-range entry i matches a word w when lo <= w < its own address register. Here lo is 0 for entry 0 and the address register of entry i-1 otherwise, and every bound is in 4-byte units. The lower bound is tested against each word's own address.
- R6: A power-of-two entry whose address register ends in t one bits covers 2^(t+3) bytes, aligned to that size, and contains the address register's value with those bits cleared.
- R7: An access covers the words from `req_addr>>2` through `(req_addr+req_len-1)>>2`. If the deciding entry matches some of those words but not all of them, the access is denied.
- R8: When several entries touch an access, the lowest-numbered one decides, even when a higher entry would cover the access fully.
- R9: In machine mode (`req_priv` = 3), an access that no entry touches is permitted, and a fully covering entry with its lock clear permits the access regardless of its permission bits. A locked entry applies its permission bits.
- R10: In any other privilege mode (0, 1 or 2), when at least one entry is active, an access that no entry touches is denied. A fully covering entry applies its permission bits whatever its lock.
- R11: `req_type` selects the permission bit that is tested: 0 read, 1 write, 2 execute. The value 3 is always denied whenever permission bits are applied.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present this cycle |
| req_addr | input | 32 | Byte start address of the access |
| req_len | input | 4 | Access length in bytes, 1 to 8 |
| req_type | input | 2 | 0 read, 1 write, 2 execute |
| req_priv | input | 2 | Privilege mode: 0 user, 1 supervisor, 3 machine |
| cfg_bytes | input | 64 | Configuration byte of each of 8 entries |
| cfg_addr | input | 240 | Address register of each of 8 entries, 30 bits each |
| rsp_valid | output | 1 | Result present this cycle |
| rsp_allow | output | 1 | Access permitted |

## Verification
The properties assume that every request carries a length from 1 to the maximum of 8 bytes, and one property checks this at the request port. They also assume that the configuration vectors do not change in the cycle a request is sampled. The properties judge the result from the configuration seen with the request. The bench changes the entries only while `req_valid` is low, and it uses only lengths of 1, 2, 4 and 8. It places every region well inside the address space, so that no access wraps past the top address.

// File: rtl/pmp_pkg.sv
package pmp_pkg;

    typedef enum logic [1:0] {
        AM_OFF   = 2'd0,
        AM_TOR   = 2'd1,
        AM_NA4   = 2'd2,
        AM_NAPOT = 2'd3
    } amode_e;

    typedef enum logic [1:0] {
        ACC_READ  = 2'd0,
        ACC_WRITE = 2'd1,
        ACC_EXEC  = 2'd2
    } acc_e;

    localparam logic [1:0] PRIV_MACHINE = 2'd3;

    // one entry's configuration byte, MSB first
    typedef struct packed {
        logic       lock;
        logic [1:0] rsvd;
        amode_e     mode;
        logic       x;
        logic       w;
        logic       r;
    } cfg_t;

endpackage

// File: rtl/pmp_sector_split.sv
module pmp_sector_split #(
    parameter int ADDR_W    = 32,
    parameter int MAX_BYTES = 8,
    parameter int LEN_W     = $clog2(MAX_BYTES + 1),
    parameter int NSEC      = MAX_BYTES / 4 + 1,
    parameter int PADDR_W   = ADDR_W - 2
) (
    input  logic [ADDR_W-1:0]             addr,
    input  logic [LEN_W-1:0]              len,
    output logic [NSEC-1:0][PADDR_W-1:0]  sec_word,
    output logic [NSEC-1:0]               sec_vld
);
    localparam int OFF_W = LEN_W + 1;

    // byte offset of the last byte, counted from the first word's start
    logic [OFF_W-1:0] last_off;

    always_comb begin
        last_off = OFF_W'(addr[1:0]) + OFF_W'(len) - OFF_W'(1);
    end

    for (genvar k = 0; k < NSEC; k++) begin : g_sec
        assign sec_word[k] = addr[ADDR_W-1:2] + PADDR_W'(k);
        assign sec_vld[k]  = (last_off >= OFF_W'(4 * k));
    end

endmodule

// File: rtl/pmp_entry_match.sv
module pmp_entry_match
    import pmp_pkg::*;
#(
    parameter int PADDR_W = 30,
    parameter int NSEC    = 3
) (
    input  cfg_t                          cfg,
    input  logic [PADDR_W-1:0]            top_word,
    input  logic [PADDR_W-1:0]            lo_word,
    input  logic [NSEC-1:0][PADDR_W-1:0]  sec_word,
    input  logic [NSEC-1:0]               sec_vld,
    output logic                          hit_any,
    output logic                          hit_all
);
    logic [PADDR_W-1:0] napot_mask;
    logic [NSEC-1:0]    sec_hit;

    always_comb begin
        // low t+1 bits set, t = trailing ones of the address register
        napot_mask = top_word ^ (top_word + PADDR_W'(1));
        for (int k = 0; k < NSEC; k++) begin
            unique case (cfg.mode)
                AM_TOR:   sec_hit[k] = (sec_word[k] >= lo_word) && (sec_word[k] < top_word);
                AM_NA4:   sec_hit[k] = (sec_word[k] == top_word);
                AM_NAPOT: sec_hit[k] = ((sec_word[k] ^ top_word) & ~napot_mask) == '0;
                default:  sec_hit[k] = 1'b0;
            endcase
        end
        hit_any = |(sec_hit & sec_vld);
        hit_all = &(sec_hit | ~sec_vld);
    end

endmodule

// File: rtl/pmp_resolve.sv
module pmp_resolve
    import pmp_pkg::*;
#(
    parameter int NUM_ENTRIES = 8
) (
    input  logic [NUM_ENTRIES*8-1:0]  cfg_bytes,
    input  logic [NUM_ENTRIES-1:0]    hit_any,
    input  logic [NUM_ENTRIES-1:0]    hit_all,
    input  logic [1:0]                acc_type,
    input  logic [1:0]                priv,
    output logic                      allow
);
    cfg_t sel_cfg;
    cfg_t cur_cfg;
    logic found;
    logic sel_full;
    logic any_active;
    logic perm_ok;
    logic is_machine;

    always_comb begin
        found      = 1'b0;
        sel_full   = 1'b0;
        sel_cfg    = '0;
        any_active = 1'b0;
        // walk downward so the lowest touching index is kept last
        for (int i = NUM_ENTRIES - 1; i >= 0; i--) begin
            cur_cfg = cfg_t'(cfg_bytes[8*i +: 8]);
            if (cur_cfg.mode != AM_OFF) any_active = 1'b1;
            if (hit_any[i]) begin
                found    = 1'b1;
                sel_full = hit_all[i];
                sel_cfg  = cur_cfg;
            end
        end

        unique case (acc_e'(acc_type))
            ACC_READ:  perm_ok = sel_cfg.r;
            ACC_WRITE: perm_ok = sel_cfg.w;
            ACC_EXEC:  perm_ok = sel_cfg.x;
            default:   perm_ok = 1'b0;
        endcase

        is_machine = (priv == PRIV_MACHINE);

        if (!any_active)                   allow = 1'b1;
        else if (!found)                   allow = is_machine;
        else if (!sel_full)                allow = 1'b0;
        else if (is_machine && !sel_cfg.lock) allow = 1'b1;
        else                               allow = perm_ok;
    end

endmodule

// File: rtl/pmp_access_checker.sv
module pmp_access_checker
    import pmp_pkg::*;
#(
    parameter int NUM_ENTRIES = 8,
    parameter int ADDR_W      = 32,
    parameter int MAX_BYTES   = 8,
    localparam int PADDR_W    = ADDR_W - 2,
    localparam int LEN_W      = $clog2(MAX_BYTES + 1)
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          req_valid,
    input  logic [ADDR_W-1:0]             req_addr,
    input  logic [LEN_W-1:0]              req_len,
    input  logic [1:0]                    req_type,
    input  logic [1:0]                    req_priv,
    input  logic [NUM_ENTRIES*8-1:0]      cfg_bytes,
    input  logic [NUM_ENTRIES*PADDR_W-1:0] cfg_addr,
    output logic                          rsp_valid,
    output logic                          rsp_allow
);
    localparam int NSEC = MAX_BYTES / 4 + 1;

    typedef struct packed {
        logic valid;
        logic allow;
    } state_t;

    state_t state_d;
    state_t state_q;

    logic [NSEC-1:0][PADDR_W-1:0] sec_word;
    logic [NSEC-1:0]              sec_vld;
    logic [NUM_ENTRIES-1:0]       hit_any;
    logic [NUM_ENTRIES-1:0]       hit_all;
    logic                         allow_c;

    pmp_sector_split #(
        .ADDR_W    (ADDR_W),
        .MAX_BYTES (MAX_BYTES),
        .LEN_W     (LEN_W),
        .NSEC      (NSEC),
        .PADDR_W   (PADDR_W)
    ) i_split (
        .addr     (req_addr),
        .len      (req_len),
        .sec_word (sec_word),
        .sec_vld  (sec_vld)
    );

    for (genvar i = 0; i < NUM_ENTRIES; i++) begin : g_ent
        logic [PADDR_W-1:0] lo_word;
        if (i == 0) begin : g_first
            assign lo_word = '0;
        end else begin : g_rest
            assign lo_word = cfg_addr[PADDR_W*(i-1) +: PADDR_W];
        end

        pmp_entry_match #(
            .PADDR_W (PADDR_W),
            .NSEC    (NSEC)
        ) i_match (
            .cfg      (cfg_t'(cfg_bytes[8*i +: 8])),
            .top_word (cfg_addr[PADDR_W*i +: PADDR_W]),
            .lo_word  (lo_word),
            .sec_word (sec_word),
            .sec_vld  (sec_vld),
            .hit_any  (hit_any[i]),
            .hit_all  (hit_all[i])
        );
    end

    pmp_resolve #(
        .NUM_ENTRIES (NUM_ENTRIES)
    ) i_resolve (
        .cfg_bytes (cfg_bytes),
        .hit_any   (hit_any),
        .hit_all   (hit_all),
        .acc_type  (req_type),
        .priv      (req_priv),
        .allow     (allow_c)
    );

    always_comb begin
        state_d       = state_q;
        state_d.valid = req_valid;
        state_d.allow = req_valid & allow_c;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= '0;
        else        state_q <= state_d;
    end

    assign rsp_valid = state_q.valid;
    assign rsp_allow = state_q.allow;

endmodule

// File: rtl/pmp_access_checker_chk.sv
module pmp_access_checker_chk
    import pmp_pkg::*;
#(
    parameter int NUM_ENTRIES = 8,
    parameter int MAX_BYTES   = 8,
    parameter int ADDR_W      = 32,
    parameter int LEN_W       = 4
) (
    input logic                     clk,
    input logic                     rst_n,
    input logic                     req_valid,
    input logic [ADDR_W-1:0]        req_addr,
    input logic [LEN_W-1:0]         req_len,
    input logic [1:0]               req_priv,
    input logic [NUM_ENTRIES*8-1:0] cfg_bytes,
    input logic                     rsp_valid,
    input logic                     rsp_allow
);
    cfg_t ent;
    logic any_active;
    logic any_lock;
    logic no_perms;
    logic one_word;

    always_comb begin
        any_active = 1'b0;
        any_lock   = 1'b0;
        no_perms   = 1'b1;
        for (int i = 0; i < NUM_ENTRIES; i++) begin
            ent = cfg_t'(cfg_bytes[8*i +: 8]);
            if (ent.mode != AM_OFF) any_active = 1'b1;
            if (ent.lock) any_lock = 1'b1;
            if (ent.r | ent.w | ent.x) no_perms = 1'b0;
        end
        one_word = (req_addr[1:0] == 2'b00) && (req_len <= LEN_W'(4));
    end

    // R1
    rsp_follows_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |=> rsp_valid);

    // R1
    rsp_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |=> !rsp_valid);

    // R1
    allow_needs_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !rsp_valid |-> !rsp_allow);

    // R2
    all_off_permits_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !any_active) |=> rsp_allow);

    // R10
    low_priv_no_perm_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && any_active && no_perms && req_priv != PRIV_MACHINE) |=> !rsp_allow);

    // R9
    machine_unlocked_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_priv == PRIV_MACHINE && !any_lock && one_word) |=> rsp_allow);

    // R7
    len_in_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |-> (req_len != '0 && req_len <= LEN_W'(MAX_BYTES)));

endmodule

bind pmp_access_checker pmp_access_checker_chk #(
    .NUM_ENTRIES (NUM_ENTRIES),
    .MAX_BYTES   (MAX_BYTES),
    .ADDR_W      (ADDR_W),
    .LEN_W       (LEN_W)
) i_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_valid (req_valid),
    .req_addr  (req_addr),
    .req_len   (req_len),
    .req_priv  (req_priv),
    .cfg_bytes (cfg_bytes),
    .rsp_valid (rsp_valid),
    .rsp_allow (rsp_allow)
);

// File: tb/test_pmp_access_checker.sv
`timescale 1ns/1ps
module test_pmp_access_checker;

    localparam int N = 8;
    localparam logic [1:0] RD = 2'd0, WR = 2'd1, EX = 2'd2;
    localparam logic [1:0] PU = 2'd0, PS = 2'd1, PM = 2'd3;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         req_valid = 1'b0;
    logic [31:0]  req_addr = '0;
    logic [3:0]   req_len = 4'd4;
    logic [1:0]   req_type = '0;
    logic [1:0]   req_priv = '0;
    logic [N*8-1:0]  cfg_bytes = '0;
    logic [N*30-1:0] cfg_addr = '0;
    logic         rsp_valid;
    logic         rsp_allow;

    int vectors = 0;
    int errors  = 0;
    bit done    = 1'b0;

    always #2.5 clk = ~clk;

    pmp_access_checker i_pmp_access_checker (
        .clk       (clk),
        .rst_n     (rst_n),
        .req_valid (req_valid),
        .req_addr  (req_addr),
        .req_len   (req_len),
        .req_type  (req_type),
        .req_priv  (req_priv),
        .cfg_bytes (cfg_bytes),
        .cfg_addr  (cfg_addr),
        .rsp_valid (rsp_valid),
        .rsp_allow (rsp_allow)
    );

    task automatic check(string tag, logic actual, logic expected);
        vectors++;
        if (actual !== expected) begin
            errors++;
            $display("FAIL %s: actual %0b expected %0b", tag, actual, expected);
        end
    endtask

    task automatic clear_entries();
        cfg_bytes = '0;
        cfg_addr  = '0;
    endtask

    task automatic set_entry(int i, logic [7:0] c, logic [29:0] a);
        cfg_bytes[8*i +: 8]  = c;
        cfg_addr[30*i +: 30] = a;
    endtask

    task automatic access(logic [31:0] a, logic [3:0] l, logic [1:0] t,
                          logic [1:0] p, logic exp, string tag);
        @(negedge clk);
        req_addr  = a;
        req_len   = l;
        req_type  = t;
        req_priv  = p;
        req_valid = 1'b1;
        @(negedge clk);
        req_valid = 1'b0;
        check({tag, " valid"}, rsp_valid, 1'b1);
        check(tag, rsp_allow, exp);
    endtask

    task automatic t_reset();
        check("R1 reset valid", rsp_valid, 1'b0);
        check("R1 reset allow", rsp_allow, 1'b0);
    endtask

    task automatic t_all_off();
        clear_entries();
        access(32'h1000, 4, WR, PU, 1'b1, "R2 off user write");
        access(32'h7FF0, 8, EX, PS, 1'b1, "R2 off super exec");
        @(negedge clk);
        check("R1 idle valid", rsp_valid, 1'b0);
        check("R1 idle allow", rsp_allow, 1'b0);
    endtask

    task automatic t_na4_lock();
        clear_entries();
        set_entry(0, 8'h90, 30'h400);
        access(32'h1000, 4, RD, PM, 1'b0, "R4 locked word load");
        access(32'h1004, 4, RD, PM, 1'b1, "R9 machine miss");
        clear_entries();
        set_entry(1, 8'h90, 30'h800);
        access(32'h2000, 4, RD, PM, 1'b0, "R3 entry1 byte1 load");
        access(32'h2002, 2, RD, PM, 1'b0, "R4 halfword inside word");
    endtask

    task automatic t_lock_modes();
        clear_entries();
        set_entry(0, 8'h10, 30'h400);
        access(32'h1000, 4, RD, PM, 1'b1, "R9 unlocked no perms machine");
        access(32'h1000, 4, RD, PU, 1'b0, "R10 unlocked no perms user");
        access(32'h1010, 4, RD, PU, 1'b0, "R10 user miss");
        access(32'h1010, 4, RD, 2'd2, 1'b0, "R10 priv 2 miss");
    endtask

    task automatic t_kinds();
        clear_entries();
        set_entry(0, 8'h92, 30'h400);
        access(32'h1000, 4, WR, PM, 1'b1, "R11 write granted");
        access(32'h1000, 4, RD, PM, 1'b0, "R11 read refused");
        access(32'h1000, 4, EX, PM, 1'b0, "R11 exec refused");
        set_entry(0, 8'h94, 30'h400);
        access(32'h1000, 4, EX, PU, 1'b1, "R11 exec granted");
        access(32'h1000, 4, 2'd3, PU, 1'b0, "R11 type 3 refused");
    endtask

    task automatic t_tor();
        clear_entries();
        set_entry(0, 8'h00, 30'h400);
        set_entry(1, 8'h09, 30'h800);
        access(32'h1000, 4, RD, PU, 1'b1, "R5 tor bottom");
        access(32'h1FFC, 4, RD, PU, 1'b1, "R5 tor last word");
        access(32'h2000, 4, RD, PU, 1'b0, "R5 tor top excluded");
        access(32'h0FFC, 4, RD, PU, 1'b0, "R5 tor below base");
        access(32'h0FFE, 4, RD, PU, 1'b0, "R7 tor straddle base");
        access(32'h1FFE, 4, RD, PU, 1'b0, "R7 tor straddle top");
        clear_entries();
        set_entry(0, 8'h09, 30'h400);
        access(32'h0000, 4, RD, PU, 1'b1, "R5 entry0 floor zero");
        access(32'h1000, 4, RD, PU, 1'b0, "R5 entry0 top");
    endtask

    task automatic t_napot();
        clear_entries();
        set_entry(0, 8'h1B, 30'h1007);
        access(32'h4000, 4, RD, PU, 1'b1, "R6 napot first");
        access(32'h403C, 4, WR, PU, 1'b1, "R6 napot last");
        access(32'h4040, 4, RD, PU, 1'b0, "R6 napot past end");
        access(32'h3FFC, 4, RD, PU, 1'b0, "R6 napot before");
        access(32'h4038, 8, RD, PU, 1'b1, "R7 napot two words inside");
        access(32'h403C, 8, RD, PU, 1'b0, "R7 napot straddle end");
        access(32'h4001, 1, EX, PU, 1'b0, "R6 napot no exec");
    endtask

    task automatic t_priority();
        clear_entries();
        set_entry(0, 8'h10, 30'h400);
        set_entry(1, 8'h1F, 30'h407);
        access(32'h1000, 4, RD, PU, 1'b0, "R8 entry0 wins");
        access(32'h1004, 4, RD, PU, 1'b1, "R8 entry1 covers");
        access(32'h1000, 8, RD, PU, 1'b0, "R8 entry0 partial wins");
        access(32'h1004, 8, EX, PU, 1'b1, "R8 entry1 two words");
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_all_off();
        t_na4_lock();
        t_lock_modes();
        t_kinds();
        t_tor();
        t_napot();
        t_priority();
        @(negedge clk);
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            vectors++;
            errors++;
            $display("FAIL watchdog: actual running expected finished");
            $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
            $finish;
        end
    end

endmodule